// File: doc/BRIEF.md
# Two-Address Operand-Steering ALU

This block is the arithmetic core of a small two-address machine whose only arithmetic element is an adder. No opcode reaches it. A handful of steering bits set its behaviour. The A operand is taken from the memory byte or from the immediate byte, and it can be inverted. The B operand can be forced to zero. The carry into the adder is chosen from zero, one or the stored carry flag. Subtract, negate, move, clear, set-carry and the zero test used by compare-and-branch are all combinations of these bits. A bitwise AND path handles mask and bit-clear operations. A separate right-shift multiplexer handles logical shift, shift with ones fill and rotate right.

Each cycle in which `opValid` is high, the block registers four things: the result byte, the new carry flag, a zero indication of the result and the sign bit of the selected A operand, taken before inversion. The carry flag is kept inside the block and fed back as the flag carry-in source. Memory access, fetch and branching are left to the surrounding machine.

Top module: `twoaddr_alu`

## Requirements
- R1: While `rstN` is low and after its release, until the first accepted operation, `result` is 0x00, `carry` is 0, `zero` is 1 and `signA` is 0.
- R2: In add mode (`andMode`=0, `shiftRight`=0), `result` is the low 8 bits of A' + B' + cin and `carry` is bit 8 of that sum. A' is the selected A operand, inverted when `cplA`=1. B' is `bData` when `bEnable`=1 and 0x00 otherwise.
- R3: `immSel`=1 selects `immData` as the A operand and `immSel`=0 selects `aData`.
- R4: `cinSel` encodes the carry-in: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives the stored carry flag, and 2'b11 gives 0.
- R5: With `cplA`=1, `bEnable`=1 and `cinSel`=2'b01 in add mode, `result` is B − A mod 256 and `carry` is 1 exactly when B ≥ A unsigned.
- R6: With `cplA`=1, `bEnable`=0 and `cinSel`=2'b01 in add mode, `result` is −A mod 256 and `carry` is 1 exactly when A is 0x00.
- R7: An immediate 0xFF with B masked, no inversion and `cinSel`=2'b10 leaves the carry flag unchanged. `result` is then 0x00 if the flag was 1 and 0xFF if it was 0.
- R8: In AND mode (`andMode`=1, `shiftRight`=0), `result` is B' & A' and the carry flag is unchanged.
- R9: With `shiftRight`=1, whatever the value of `andMode`, `result` is A' shifted right by one, with bit 7 filled from the selected carry-in, and `carry` takes bit 0 of A'.
- R10: `zero` is 1 exactly when `result` is 0x00. `signA` is bit 7 of the selected A operand before inversion.
- R11: While `opValid` is low, `result`, `carry`, `zero` and `signA` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Accept the operation on this edge |
| aData | input | 8 | A operand from memory |
| immData | input | 8 | A operand from the immediate field |
| bData | input | 8 | B operand from memory |
| immSel | input | 1 | Use the immediate byte as A |
| cplA | input | 1 | Invert the A operand |
| bEnable | input | 1 | Pass B (0 forces B to zero) |
| cinSel | input | 2 | Carry-in source select |
| andMode | input | 1 | Bitwise AND instead of add |
| shiftRight | input | 1 | Right shift of A' (overrides AND) |
| result | output | 8 | Registered result byte |
| carry | output | 1 | Registered carry flag |
| zero | output | 1 | Registered result-is-zero indication |
| signA | output | 1 | Registered sign of the selected A operand |

## Verification
The assertions assume that `opValid` is held low while `rstN` is low. They also assume that every input is at a known level at each rising edge, since the carry and hold properties compare values sampled one cycle apart. The stimulus drives every input only on falling edges, drives none of them during reset and gives all of them defined values before reset is released. The sweep walks every combination of the steering bits, with both carry states set up beforehand through an ordinary set-carry or clear-carry operation, so that the flag input of the carry-in selector is always known.

// File: rtl/twoaddr_alu_pkg.sv
package twoaddr_alu_pkg;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'b00,
    CIN_ONE  = 2'b01,
    CIN_FLAG = 2'b10,
    CIN_SPARE = 2'b11
  } cinSrc_e;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic loadEn;
    logic useImm;
    logic invertA;
    logic maskB;
    logic cinBit;
    logic pathAdd;
    logic pathAnd;
    logic pathShift;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import twoaddr_alu_pkg::*;
(
  input  logic        opValid,
  input  logic        immSel,
  input  logic        cplA,
  input  logic        bEnable,
  input  logic [1:0]  cinSel,
  input  logic        andMode,
  input  logic        shiftRight,
  input  logic        carryFlag,
  output aluStrobes_t strobes
);

  cinSrc_e cinSrc;
  logic    cinPick;

  assign cinSrc = cinSrc_e'(cinSel);

  always_comb begin
    unique case (cinSrc)
      CIN_ONE:  cinPick = 1'b1;
      CIN_FLAG: cinPick = carryFlag;
      default:  cinPick = 1'b0;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.loadEn    = opValid;
    strobes.useImm    = immSel;
    strobes.invertA   = cplA;
    strobes.maskB     = ~bEnable;
    strobes.cinBit    = cinPick;
    // shift path wins over AND; the adder is the default path
    strobes.pathShift = shiftRight;
    strobes.pathAnd   = andMode & ~shiftRight;
    strobes.pathAdd   = ~andMode & ~shiftRight;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import twoaddr_alu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] aData,
  input  logic [WIDTH-1:0] immData,
  input  logic [WIDTH-1:0] bData,
  input  logic             carryFlag,
  output logic [WIDTH-1:0] resNext,
  output logic             carryNext,
  output logic             zeroNext,
  output logic             signNext
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] aSel;
  logic [WIDTH-1:0] aEff;
  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumBits;
  logic             sumCarry;
  logic [WIDTH-1:0] andBits;
  logic [WIDTH-1:0] shiftBits;

  // operand steering: source mux and inverter on A, zero mask on B
  assign aSel = strobes.useImm  ? immData : aData;
  assign aEff = strobes.invertA ? ~aSel   : aSel;
  assign bEff = strobes.maskB   ? '0      : bData;

  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = strobes.cinBit;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sumBits[i]  = aEff[i] ^ bEff[i] ^ chain[i];
        assign chain[i+1]  = (aEff[i] & bEff[i]) | (chain[i] & (aEff[i] ^ bEff[i]));
      end
      assign sumCarry = chain[WIDTH];
    end else begin : g_flat
      logic [WIDTH:0] wide;
      assign wide     = {1'b0, aEff} + {1'b0, bEff} + {{WIDTH{1'b0}}, strobes.cinBit};
      assign sumBits  = wide[MSB:0];
      assign sumCarry = wide[WIDTH];
    end
  endgenerate

  assign andBits   = aEff & bEff;
  assign shiftBits = {strobes.cinBit, aEff[MSB:1]};

  always_comb begin
    resNext   = sumBits;
    carryNext = sumCarry;
    if (strobes.pathShift) begin
      resNext   = shiftBits;
      carryNext = aEff[0];
    end else if (strobes.pathAnd) begin
      resNext   = andBits;
      carryNext = carryFlag;
    end
  end

  assign zeroNext = (resNext == '0);
  assign signNext = aSel[MSB];

endmodule

// File: rtl/twoaddr_alu.sv
module twoaddr_alu
  import twoaddr_alu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [WIDTH-1:0] aData,
  input  logic [WIDTH-1:0] immData,
  input  logic [WIDTH-1:0] bData,
  input  logic             immSel,
  input  logic             cplA,
  input  logic             bEnable,
  input  logic [1:0]       cinSel,
  input  logic             andMode,
  input  logic             shiftRight,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             zero,
  output logic             signA
);

  aluStrobes_t      strobes;
  logic [WIDTH-1:0] resNext;
  logic             carryNext;
  logic             zeroNext;
  logic             signNext;

  alu_ctrl u_ctrl (
    .opValid    (opValid),
    .immSel     (immSel),
    .cplA       (cplA),
    .bEnable    (bEnable),
    .cinSel     (cinSel),
    .andMode    (andMode),
    .shiftRight (shiftRight),
    .carryFlag  (carry),
    .strobes    (strobes)
  );

  alu_datapath #(
    .WIDTH  (WIDTH),
    .RIPPLE (RIPPLE)
  ) u_dp (
    .strobes   (strobes),
    .aData     (aData),
    .immData   (immData),
    .bData     (bData),
    .carryFlag (carry),
    .resNext   (resNext),
    .carryNext (carryNext),
    .zeroNext  (zeroNext),
    .signNext  (signNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      carry  <= 1'b0;
      zero   <= 1'b1;
      signA  <= 1'b0;
    end else if (strobes.loadEn) begin
      result <= resNext;
      carry  <= carryNext;
      zero   <= zeroNext;
      signA  <= signNext;
    end
  end

  // port-level views used by the properties below
  logic [WIDTH-1:0] aPort;
  logic             addMode;
  assign aPort   = immSel ? immData : aData;
  assign addMode = ~andMode & ~shiftRight;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(result) && $stable(carry) && $stable(zero) && $stable(signA));

  p_and_keeps_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    opValid && andMode && !shiftRight |=> carry == $past(carry));

  p_shift_lsb_carry_r9: assert property (@(posedge clk) disable iff (!rstN)
    opValid && shiftRight |=> carry == $past(aPort[0] ^ cplA));

  p_neg_zero_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    opValid && addMode && cplA && !bEnable && cinSel == 2'b01
    |=> carry == ($past(aPort) == '0));

  p_nop_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    opValid && addMode && !cplA && !bEnable && cinSel == 2'b10 && aPort == '1
    |=> carry == $past(carry));

  p_zero_tracks_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    zero == (result == '0));

endmodule

// File: tb/sim_twoaddr_alu.sv
module sim_twoaddr_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] aData = '0, immData = '0, bData = '0;
  logic       immSel = 1'b0, cplA = 1'b0, bEnable = 1'b0;
  logic [1:0] cinSel = '0;
  logic       andMode = 1'b0, shiftRight = 1'b0;
  logic [7:0] result;
  logic       carry, zero, signA;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoaddr_alu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid),
    .aData(aData), .immData(immData), .bData(bData),
    .immSel(immSel), .cplA(cplA), .bEnable(bEnable), .cinSel(cinSel),
    .andMode(andMode), .shiftRight(shiftRight),
    .result(result), .carry(carry), .zero(zero), .signA(signA)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // apply one operation for one clock; outputs are valid on return
  task automatic doOp(input logic [7:0] a, input logic [7:0] im, input logic [7:0] b,
                      input logic isImm, input logic cpl, input logic ben,
                      input logic [1:0] cs, input logic am, input logic sr);
    @(negedge clk);
    aData = a; immData = im; bData = b;
    immSel = isImm; cplA = cpl; bEnable = ben; cinSel = cs;
    andMode = am; shiftRight = sr; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic setCarry(input logic v);
    // immediate 0xFF + 0 + 1 sets carry; all-zero controls clear it
    if (v) doOp(8'h00, 8'hFF, 8'h00, 1, 0, 0, 2'b01, 0, 0);
    else   doOp(8'h00, 8'h00, 8'h00, 0, 0, 0, 2'b00, 0, 0);
  endtask

  // expected {carry, result} from the requirements
  function automatic logic [8:0] expect9(input logic [7:0] a, input logic [7:0] im,
      input logic [7:0] b, input logic isImm, input logic cpl, input logic ben,
      input logic [1:0] cs, input logic am, input logic sr, input logic cf);
    logic [7:0] av, bv;
    logic ci;
    av = isImm ? im : a;
    if (cpl) av = 8'hFF - av;
    bv = ben ? b : 8'h00;
    ci = (cs == 2'b01) ? 1'b1 : ((cs == 2'b10) ? cf : 1'b0);
    if (sr)      return {av[0], ci, av[7:1]};
    else if (am) return {cf, bv & av};
    else         return 9'({1'b0, av} + {1'b0, bv} + {8'd0, ci});
  endfunction

  function automatic logic [7:0] pickVal(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
      4: return 8'hFF; 5: return 8'h55; 6: return 8'hAA; 7: return 8'h0F;
      8: return 8'hF0; default: return 8'h3C;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    logic [7:0] hr; logic hc, hz, hs;
    repeat (3) @(negedge clk);
    // R1 during reset and after release
    chk("R1 result in reset", result, 8'h00);
    chk("R1 carry in reset", carry, 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 result", result, 8'h00);
    chk("R1 carry", carry, 0);
    chk("R1 zero", zero, 1);
    chk("R1 signA", signA, 0);

    // R3 source select
    doOp(8'h12, 8'h34, 8'h99, 1, 0, 0, 2'b00, 0, 0);
    chk("R3 immediate picked", result, 8'h34);
    doOp(8'h12, 8'h34, 8'h99, 0, 0, 0, 2'b00, 0, 0);
    chk("R3 memory picked", result, 8'h12);

    // R4 spare code gives carry-in 0 even with flag set
    setCarry(1);
    doOp(8'h10, 8'h00, 8'h00, 0, 0, 0, 2'b11, 0, 0);
    chk("R4 spare code cin", result, 8'h10);
    setCarry(1);
    doOp(8'h10, 8'h00, 8'h00, 0, 0, 0, 2'b10, 0, 0);
    chk("R4 flag code cin", result, 8'h11);

    // R5 reverse subtract
    doOp(8'h10, 8'h00, 8'h30, 0, 1, 1, 2'b01, 0, 0);
    chk("R5 diff", result, 8'h20);
    chk("R5 no borrow", carry, 1);
    doOp(8'h30, 8'h00, 8'h10, 0, 1, 1, 2'b01, 0, 0);
    chk("R5 wrapped diff", result, 8'hE0);
    chk("R5 borrow", carry, 0);

    // R6 negate, carry flags zero
    doOp(8'h00, 8'h00, 8'h77, 0, 1, 0, 2'b01, 0, 0);
    chk("R6 neg zero", result, 8'h00);
    chk("R6 carry on zero", carry, 1);
    doOp(8'h05, 8'h00, 8'h77, 0, 1, 0, 2'b01, 0, 0);
    chk("R6 neg five", result, 8'hFB);
    chk("R6 carry nonzero", carry, 0);

    // R7 nop keeps carry
    setCarry(1);
    doOp(8'h00, 8'hFF, 8'h12, 1, 0, 0, 2'b10, 0, 0);
    chk("R7 carry kept 1", carry, 1);
    chk("R7 result", result, 8'h00);
    setCarry(0);
    doOp(8'h00, 8'hFF, 8'h12, 1, 0, 0, 2'b10, 0, 0);
    chk("R7 carry kept 0", carry, 0);
    chk("R7 result", result, 8'hFF);

    // R9 shift overrides AND; rotate brings carry into bit 7
    setCarry(1);
    doOp(8'h03, 8'h00, 8'h00, 0, 0, 1, 2'b10, 1, 1);
    chk("R9 rotate result", result, 8'h81);
    chk("R9 rotate carry", carry, 1);

    // R11 hold while opValid low
    doOp(8'h21, 8'h00, 8'h40, 0, 0, 1, 2'b00, 0, 0);
    hr = result; hc = carry; hz = zero; hs = signA;
    @(negedge clk);
    aData = 8'hFF; bData = 8'hFF; immSel = 1'b1; immData = 8'h80;
    cplA = 1'b1; cinSel = 2'b01;
    repeat (3) @(negedge clk);
    chk("R11 result held", result, hr);
    chk("R11 carry held", carry, hc);
    chk("R11 zero held", zero, hz);
    chk("R11 sign held", signA, hs);

    // sweep of every steering combination (R2, R8, R9, R10)
    for (int ctl = 0; ctl < 128; ctl++) begin
      for (int ai = 0; ai < 10; ai++) begin
        for (int bi = 0; bi < 10; bi++) begin
          for (int cf = 0; cf < 2; cf++) begin
            logic [7:0] av, iv, bv, rawA;
            logic isI, cp, be, am, sr;
            logic [1:0] cs;
            string tag;
            av = pickVal(ai); iv = av ^ 8'hA5; bv = pickVal(bi);
            isI = ctl[0]; cp = ctl[1]; be = ctl[2]; cs = 2'(ctl[4:3]);
            am = ctl[5]; sr = ctl[6];
            e = expect9(av, iv, bv, isI, cp, be, cs, am, sr, cf[0]);
            rawA = isI ? iv : av;
            tag = sr ? "R9" : (am ? "R8" : "R2");
            setCarry(cf[0]);
            doOp(av, iv, bv, isI, cp, be, cs, am, sr);
            chk({tag, " result"}, result, e[7:0]);
            chk({tag, " carry"}, carry, e[8]);
            chk("R10 zero", zero, (e[7:0] == 8'h00));
            chk("R10 signA", signA, rawA[7]);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule